// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer. A free-running binary counter advances on one of two tick strobes, and a clock-mode input picks which strobe it uses. If software does not restart the count in time, the counter reaches a power-of-two limit. The block then issues a one-cycle request, either an interrupt or a reset, and the count starts again from zero. Software reaches the timer through a single write port that addresses two write-only registers: a settings register and a code register.

The settings register holds the enable bit, a two-bit period code and the action bit. Bit 3 is enable, bits 2:1 are the period code and bit 0 is the action bit. Bits 7:4 are not used by the timer. The code register responds only to key values. 0x4E restarts the count. 0xB1 stops the watchdog, but only when the enable bit is already zero. Every other value, including 0xD2, has no effect on the timer. The timer therefore cannot be stopped by a single stray write. The action bit can be cleared but never set again until reset.

Top module: `kwdt_top`

## Requirements
- R1: While `rst_n` is low both request outputs are low. After reset the watchdog runs with period code 00 and action bit 1, so its first timeout raises `rst_req`.
- R2: Each selected tick advances the count. In the cycle after the 2^E-th tick following a restart, exactly one of the outputs pulses high for one cycle. The count then restarts from 0, so the next pulse follows 2^E ticks later.
- R3: With `slow_sel`=0, E is HI_EXP_MAX minus twice the period code (25, 23, 21, 19 by default). With `slow_sel`=1, E is LO_EXP_MAX minus twice the code (17, 15, 13, 11 by default).
- R4: The count advances only on the strobe chosen by `slow_sel`: `hf_tick` when it is 0, `lf_tick` when it is 1. The other strobe is ignored.
- R5: Writing 0x4E to the code register (`wr_sel`=1) sets the count to 0.
- R6: A code-register write of any value other than 0x4E or 0xB1, including 0xD2, leaves the count and the timer state unchanged.
- R7: Writing 0xB1 while the enable bit is 0 stops the watchdog and zeroes the count. No request is raised while it is stopped.
- R8: 0xB1 written while the enable bit is 1 is ignored. Writing 0 to the enable bit alone leaves the watchdog running.
- R9: Writing the settings register with the enable bit set restarts a stopped watchdog, counting from 0.
- R10: Action bit 0 selects `irq_req` and action bit 1 selects `rst_req`. Once the bit has been written to 0, later writes of 1 are ignored until reset.
- R11: `irq_req` and `rst_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hf_tick | input | 1 | High-frequency count strobe |
| lf_tick | input | 1 | Low-frequency count strobe |
| slow_sel | input | 1 | Clock mode: 1 counts `lf_tick` with the low exponent set |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = settings register, 1 = code register |
| wr_data | input | 8 | Write data |
| irq_req | output | 1 | One-cycle timeout interrupt request |
| rst_req | output | 1 | One-cycle timeout reset request |

## Verification
The bench measures each timeout to the exact cycle from a known restart point. A design that is off by one tick, or that uses the wrong exponent for a period code, misses the expected pulse cycle. It writes 0xB1 before clearing the enable bit, which a design without the ordering check would wrongly treat as a stop. It also interleaves the unused key 0xD2 and other stray codes into a count, which catches a decoder that restarts the count on anything other than 0x4E. Finally, it writes the action bit back to 1 after clearing it, and checks that a re-enabled watchdog starts from zero. A non-sticky action bit would switch back to reset requests, and a count that was not zeroed would fire early.

// File: rtl/kwdt_pkg.sv
// Package: shared key values, settings-register field positions and
// the period-code width for the keyed watchdog.
package kwdt_pkg;
    localparam logic [7:0] KEY_RESTART = 8'h4E;
    localparam logic [7:0] KEY_STOP    = 8'hB1;
    localparam int         BIT_ENABLE  = 3;
    localparam int         BIT_SEL_HI  = 2;
    localparam int         BIT_SEL_LO  = 1;
    localparam int         BIT_ACTION  = 0;
    localparam int         SEL_W       = 2;
endpackage

// File: rtl/kwdt_ctrl.sv
// Module: kwdt_ctrl
// Holds the settings register and the running flag, and decodes code
// register writes. Assumes at most one write per cycle. The running
// flag drops only on a stop key written while the enable bit is 0.
module kwdt_ctrl
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic             run_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             rst_mode_o,
    output logic             restart_o
);
    logic             en_q;
    logic             run_q;
    logic [SEL_W-1:0] sel_q;
    logic             act_q;
    logic             set_wr;
    logic             code_wr;
    logic             stop_ok;

    // Purpose: split the write port into its two register strobes.
    always_comb begin
        set_wr    = wr_en && !wr_sel;
        code_wr   = wr_en && wr_sel;
        stop_ok   = code_wr && (wr_data == KEY_STOP) && !en_q;
        restart_o = code_wr && (wr_data == KEY_RESTART);
    end

    // Purpose: update the settings fields; the action bit can only fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            sel_q <= '0;
            act_q <= 1'b1;
        end else if (set_wr) begin
            en_q  <= wr_data[BIT_ENABLE];
            sel_q <= wr_data[BIT_SEL_HI:BIT_SEL_LO];
            act_q <= act_q & wr_data[BIT_ACTION];
        end
    end

    // Purpose: running flag, set by enable and cleared by a valid stop key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b1;
        end else if (set_wr && wr_data[BIT_ENABLE]) begin
            run_q <= 1'b1;
        end else if (stop_ok) begin
            run_q <= 1'b0;
        end
    end

    assign run_o      = run_q;
    assign sel_o      = sel_q;
    assign rst_mode_o = act_q;

    p_stop_needs_low_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_wr && wr_data == KEY_STOP && en_q) |=> run_q);
    p_en_low_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !wr_data[BIT_ENABLE] && run_q) |=> run_q);
    p_enable_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && wr_data[BIT_ENABLE]) |=> run_q);
    p_action_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |=> !act_q);
endmodule

// File: rtl/kwdt_counter.sv
// Module: kwdt_counter
// Binary count on the tick chosen by the clock mode. A registered
// one-cycle fire pulse is raised when the count reaches the selected
// power-of-two limit, and the count then restarts. Assumes
// LO_EXP_MAX <= HI_EXP_MAX and every selected exponent >= 1.
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int HI_EXP_MAX = 25,
    parameter int LO_EXP_MAX = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hf_tick,
    input  logic             lf_tick,
    input  logic             slow_sel,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             fire_o
);
    localparam int CW = HI_EXP_MAX;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit_m1;
    logic          tick;
    logic          fire_q;
    int            exp_sel;

    // Purpose: pick the tick strobe and build the all-ones limit mask.
    always_comb begin
        tick    = slow_sel ? lf_tick : hf_tick;
        exp_sel = slow_sel ? (LO_EXP_MAX - 2 * int'(sel_i))
                           : (HI_EXP_MAX - 2 * int'(sel_i));
        for (int i = 0; i < CW; i++) begin
            limit_m1[i] = (i < exp_sel);
        end
    end

    // Purpose: advance, restart or hold the count; raise the fire pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else if (!run_i || restart_i) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else if (tick && cnt_q >= limit_m1) begin
            cnt_q  <= '0;
            fire_q <= 1'b1;
        end else begin
            cnt_q  <= tick ? cnt_q + CW'(1) : cnt_q;
            fire_q <= 1'b0;
        end
    end

    assign fire_o = fire_q;

    p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
    p_stopped_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0 && !fire_q));
    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/kwdt_top.sv
// Module: kwdt_top
// Keyed watchdog top level. Joins the settings/code decoder to the
// counter and steers the fire pulse to the interrupt or reset request
// according to the action bit.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int HI_EXP_MAX = 25,
    parameter int LO_EXP_MAX = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hf_tick,
    input  logic       lf_tick,
    input  logic       slow_sel,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       irq_req,
    output logic       rst_req
);
    logic             run;
    logic [SEL_W-1:0] sel;
    logic             rst_mode;
    logic             restart;
    logic             fire;

    kwdt_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .run_o      (run),
        .sel_o      (sel),
        .rst_mode_o (rst_mode),
        .restart_o  (restart)
    );

    kwdt_counter #(
        .HI_EXP_MAX (HI_EXP_MAX),
        .LO_EXP_MAX (LO_EXP_MAX)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .hf_tick   (hf_tick),
        .lf_tick   (lf_tick),
        .slow_sel  (slow_sel),
        .run_i     (run),
        .restart_i (restart),
        .sel_i     (sel),
        .fire_o    (fire)
    );

    // Purpose: route the fire pulse to the selected request output.
    always_comb begin
        irq_req = fire && !rst_mode;
        rst_req = fire && rst_mode;
    end

    p_one_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_req, rst_req}));
endmodule

// File: tb/test_kwdt_top.sv
// Directed bench for kwdt_top with small exponents (HI 9, LO 7).
module test_kwdt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hf_tick = 1'b1;
    logic       lf_tick = 1'b0;
    logic       slow_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_req;
    logic       rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    kwdt_top #(.HI_EXP_MAX(9), .LO_EXP_MAX(7)) i_kwdt_top (
        .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
        .slow_sel(slow_sel), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq_req(irq_req), .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    task automatic check2(input logic a_irq, input logic a_rst,
                          input logic e_irq, input logic e_rst, input string tag);
        n_tests++;
        if (a_irq !== e_irq || a_rst !== e_rst) begin
            n_fail++;
            $display("FAIL %s: irq/rst = %b%b, expected %b%b", tag, a_irq, a_rst, e_irq, e_rst);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check2(irq_req, rst_req, 1'b0, 1'b0, "R1 outputs low in reset");
        rst_n = 1'b1;
    endtask

    task automatic wr_set(input logic en, input logic [1:0] sel, input logic act);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = {4'b1100, en, sel, act};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_code(input logic [7:0] key);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = key;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called k_now cycles after a restart edge; expects the pulse at cycle term.
    task automatic wait_pulse(input int k_now, input int term,
                              input logic e_irq, input logic e_rst, input string tag);
        repeat (term - 1 - k_now) @(negedge clk);
        check2(irq_req, rst_req, 1'b0, 1'b0, {tag, " quiet before limit"});
        @(negedge clk);
        check2(irq_req, rst_req, e_irq, e_rst, {tag, " pulse at limit"});
        @(negedge clk);
        check2(irq_req, rst_req, 1'b0, 1'b0, {tag, " pulse one cycle"});
    endtask

    task automatic watch_quiet(input int n, input string tag);
        logic seen_irq = 1'b0;
        logic seen_rst = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen_irq |= irq_req;
            seen_rst |= rst_req;
        end
        check2(seen_irq, seen_rst, 1'b0, 1'b0, tag);
    endtask

    task automatic t_reset_default();
        apply_reset();
        wait_pulse(0, 512, 1'b0, 1'b1, "R1 default reset action");
        wait_pulse(1, 512, 1'b0, 1'b1, "R2 restart after timeout");
    endtask

    task automatic t_period_codes();
        for (int c = 3; c >= 1; c--) begin
            wr_set(1'b1, 2'(c), 1'b1);
            wr_code(8'h4E);
            wait_pulse(0, 1 << (9 - 2 * c), 1'b0, 1'b1, "R3 high mode period");
        end
    endtask

    task automatic t_restart_key();
        wr_set(1'b1, 2'b11, 1'b1);
        wr_code(8'h4E);
        for (int i = 0; i < 30; i++) begin
            repeat (4) @(negedge clk);
            n_tests++;
            if (irq_req || rst_req) begin
                n_fail++;
                $display("FAIL R5: irq/rst = %b%b, expected 00", irq_req, rst_req);
            end
            wr_code(8'h4E);
        end
        wait_pulse(0, 8, 1'b0, 1'b1, "R5 limit after last restart");
    endtask

    task automatic t_stray_codes();
        wr_code(8'h4E);
        wr_code(8'hD2);
        wr_code(8'h00);
        wr_code(8'h4F);
        wr_code(8'hB1);
        wait_pulse(4, 8, 1'b0, 1'b1, "R6 stray codes ignored");
    endtask

    task automatic t_wrong_order();
        wr_code(8'hB1);
        wr_set(1'b0, 2'b11, 1'b1);
        wr_code(8'h4E);
        wait_pulse(0, 8, 1'b0, 1'b1, "R8 stop key before enable low");
    endtask

    task automatic t_proper_stop();
        wr_set(1'b0, 2'b11, 1'b1);
        wr_code(8'hB1);
        watch_quiet(300, "R7 stopped watchdog silent");
        wr_set(1'b1, 2'b11, 1'b1);
        wait_pulse(0, 8, 1'b0, 1'b1, "R9 re-enable counts from zero");
    endtask

    task automatic t_slow_mode();
        slow_sel = 1'b1; hf_tick = 1'b1; lf_tick = 1'b0;
        wr_set(1'b1, 2'b01, 1'b1);
        wr_code(8'h4E);
        watch_quiet(100, "R4 high tick ignored in slow mode");
        hf_tick = 1'b0; lf_tick = 1'b1;
        wr_code(8'h4E);
        wait_pulse(0, 32, 1'b0, 1'b1, "R3 slow mode period");
        wr_set(1'b1, 2'b11, 1'b1);
        wr_code(8'h4E);
        wait_pulse(0, 2, 1'b0, 1'b1, "R3 slow mode shortest period");
        slow_sel = 1'b0; hf_tick = 1'b1; lf_tick = 1'b1;
        wr_code(8'h4E);
        wait_pulse(0, 8, 1'b0, 1'b1, "R4 low tick ignored in fast mode");
        lf_tick = 1'b0;
    endtask

    task automatic t_action_sticky();
        wr_set(1'b1, 2'b11, 1'b0);
        wr_code(8'h4E);
        wait_pulse(0, 8, 1'b1, 1'b0, "R10 interrupt action");
        wr_set(1'b1, 2'b11, 1'b1);
        wr_code(8'h4E);
        wait_pulse(0, 8, 1'b1, 1'b0, "R10 action bit sticky");
        apply_reset();
        wait_pulse(0, 512, 1'b0, 1'b1, "R1 reset restores action");
    endtask

    initial begin
        fork
            begin
                t_reset_default();
                t_period_codes();
                t_restart_key();
                t_stray_codes();
                t_wrong_order();
                t_proper_stop();
                t_slow_mode();
                t_action_sticky();
            end
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: run not finished, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule